// File: doc/BRIEF.md
# Serial Register Target with Pointer-Based Readback

This block is the control-plane register target of a radio receiver. A host drives three serial lines (an active-low frame enable, a serial clock and a data input) and reads back through a data-out pin that the block drives only while a readback frame is open. Every frame carries 24 bits: a chip-select code, a register number and a 16-bit data word. A register changes only when the frame enable returns high after exactly 24 serial clocks and the chip code matches. The registers drive the receiver's analog and filter controls as parallel 16-bit fields.

Readback takes two frames. The host first writes a register number into a pointer location. The frame that follows is a readback frame: the block drives the selected register onto the data-out pin, most significant bit first. One location holds read-only status from the filter calibration engine, which enters as plain input ports. A write that raises the calibration-enable bit in the filter register produces a single-cycle start pulse.

The serial lines pass through two-flop synchronizers into the system clock domain and are sampled there, so the system clock must run several times faster than the serial clock.

Top module: `spi_regslave`

## Requirements
- R1: A frame is the bits sampled on rising `spi_sclk` edges while `spi_sen_n` is low, first bit first: bits 23..21 are the chip code, bits 20..16 the register number, bits 15..0 the data word, each field sent most significant bit first.
- R2: A frame is committed only if its chip code equals the parameter `CHIP_ADDR` (default 3'b110). A frame with any other code changes no register and arms no readback.
- R3: A committed write updates its register on the third rising `clk` edge after `spi_sen_n` rises. The register keeps its old value while bits are being shifted and until that edge.
- R4: A frame that ends after any clock count other than 24 (fewer, more, or 32 and beyond, with no wrap-around of the count) changes no register.
- R5: Writable registers and their reset values: 0x01 = 0xFFB6 (`cfg_enable`), 0x02 = 0xC585 (`cfg_filter`), 0x03 = 0x869F (`cfg_filter_src`), 0x04 = 0x3400 (`cfg_agc`), 0x05 = 0xA904 (`cfg_gain_limit`), 0x12 = 0xF05C (`cfg_blocker`), 0x14 = 0xF000 (`cfg_phase_i`), 0x15 = 0xF000 (`cfg_phase_q`).
- R6: Register 0x06 is read-only and reads as {6'b0, `stat_cal_ovfl`, `stat_cal_done`, `stat_cal_word`}. Writes to 0x06 and to any address not listed in R5 (other than 0x07) change nothing.
- R7: A committed write to 0x07 whose data bits 15..5 are zero stores bits 4..0 as the read pointer and arms a readback. With bits 15..5 not all zero, no readback is armed.
- R8: The frame after an armed pointer write is a readback frame. The selected register appears on `spi_sdo` MSB first: bit 15 from the start of the frame, then the next bit after each falling `spi_sclk`, then zeros after 16 bits. An unimplemented address reads 0x0000. The data shifted in during a readback frame is never committed.
- R9: `spi_sdo_oe` is high only while a readback frame is open and is low at all other times, including after a mismatched or malformed pointer write.
- R10: When a committed write to 0x02 takes bit 9 from 0 to 1, `cal_start` is high for exactly one `clk` cycle. A write that finds bit 9 already set gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sen_n | input | 1 | Frame enable, low during a frame |
| spi_sclk | input | 1 | Serial clock |
| spi_sdi | input | 1 | Serial data in |
| spi_sdo | output | 1 | Serial readback data |
| spi_sdo_oe | output | 1 | Drive enable for the readback pin |
| stat_cal_ovfl | input | 1 | Calibration overflow status |
| stat_cal_done | input | 1 | Calibration finished status |
| stat_cal_word | input | 8 | Calibrated filter tuning word |
| cfg_enable | output | 16 | Register 0x01 |
| cfg_filter | output | 16 | Register 0x02 |
| cfg_filter_src | output | 16 | Register 0x03 |
| cfg_agc | output | 16 | Register 0x04 |
| cfg_gain_limit | output | 16 | Register 0x05 |
| cfg_blocker | output | 16 | Register 0x12 |
| cfg_phase_i | output | 16 | Register 0x14 |
| cfg_phase_q | output | 16 | Register 0x15 |
| cal_start | output | 1 | One-cycle calibration start pulse |

## Verification
A register write reaches its output on the third rising `clk` edge after `spi_sen_n` rises: two synchronizer stages, then the write. The bench checks the old value after two edges and the new one after three. Readback bits settle about three `clk` cycles after each falling serial edge. The serial half period is six system cycles, so the bench samples `spi_sdo` just before each rising serial edge. All checks use values driven and sampled on the falling `clk` edge, and steady-state checks wait for the full inter-frame gap before comparing against the bench's own register model.

// File: rtl/spi_regslave_pkg.sv
package spi_regslave_pkg;
  localparam int DATA_W     = 16;
  localparam int ADDR_W     = 5;
  localparam int CHIP_W     = 3;
  localparam int FRAME_BITS = CHIP_W + ADDR_W + DATA_W;
  localparam int NUM_WR     = 8;
  localparam int STAT_PAD_W = DATA_W - 10;
  localparam logic [ADDR_W-1:0] PTR_ADDR    = 5'h07;
  localparam logic [ADDR_W-1:0] STATUS_ADDR = 5'h06;
  localparam int FILT_SLOT  = 1;
  localparam int CAL_BIT    = 9;

  function automatic logic [ADDR_W-1:0] slot_addr(input int idx);
    case (idx)
      0:       return 5'h01;
      1:       return 5'h02;
      2:       return 5'h03;
      3:       return 5'h04;
      4:       return 5'h05;
      5:       return 5'h12;
      6:       return 5'h14;
      default: return 5'h15;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] slot_reset(input int idx);
    case (idx)
      0:       return 16'hFFB6;
      1:       return 16'hC585;
      2:       return 16'h869F;
      3:       return 16'h3400;
      4:       return 16'hA904;
      5:       return 16'hF05C;
      default: return 16'hF000;
    endcase
  endfunction
endpackage

// File: rtl/spi_sync_edge.sv
module spi_sync_edge #(
  parameter int         W       = 3,
  parameter int         EDGE_W  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      d,
  output logic [W-1:0]      level,
  output logic [EDGE_W-1:0] rise,
  output logic [EDGE_W-1:0] fall
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic st1_q, st2_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st1_q <= RST_VAL[i];
        st2_q <= RST_VAL[i];
      end else begin
        st1_q <= d[i];
        st2_q <= st1_q;
      end
    end
    assign level[i] = st2_q;
    if (i < EDGE_W) begin : g_edge
      logic prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= RST_VAL[i];
        else        prev_q <= st2_q;
      end
      assign rise[i] = st2_q & ~prev_q;
      assign fall[i] = ~st2_q & prev_q;
    end
  end
endmodule

// File: rtl/spi_frame_rx.sv
module spi_frame_rx
  import spi_regslave_pkg::*;
#(
  parameter logic [CHIP_W-1:0] CHIP_ADDR = 3'b110
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sen_low,
  input  logic              sen_fall,
  input  logic              sen_rise,
  input  logic              sclk_rise,
  input  logic              sdi,
  output logic              frame_ok,
  output logic [ADDR_W-1:0] frame_addr,
  output logic [DATA_W-1:0] frame_data
);
  localparam int CNT_W = $clog2(FRAME_BITS) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);

  logic [FRAME_BITS-1:0] sr_q, sr_d;
  logic [CNT_W-1:0]      cnt_q, cnt_d;
  logic                  upd_en;

  assign upd_en = sen_fall | (sen_low & sclk_rise);

  always_comb begin
    sr_d  = sr_q;
    cnt_d = cnt_q;
    if (sen_fall) begin
      cnt_d = '0;
    end else if (sen_low && sclk_rise) begin
      sr_d = {sr_q[FRAME_BITS-2:0], sdi};
      if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (upd_en) begin
      sr_q  <= sr_d;
      cnt_q <= cnt_d;
    end
  end

  assign frame_ok   = sen_rise && (cnt_q == CNT_FULL) &&
                      (sr_q[FRAME_BITS-1 -: CHIP_W] == CHIP_ADDR);
  assign frame_addr = sr_q[DATA_W +: ADDR_W];
  assign frame_data = sr_q[DATA_W-1:0];
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
  import spi_regslave_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic [ADDR_W-1:0]        rd_addr,
  input  logic [DATA_W-1:0]        status_word,
  output logic [NUM_WR*DATA_W-1:0] bank_flat,
  output logic [DATA_W-1:0]        rd_data,
  output logic                     cal_start
);
  for (genvar g = 0; g < NUM_WR; g++) begin : g_slot
    logic              hit;
    logic [DATA_W-1:0] val_q;
    assign hit = wr_en && (wr_addr == slot_addr(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   val_q <= slot_reset(g);
      else if (hit) val_q <= wr_data;
    end
    assign bank_flat[g*DATA_W +: DATA_W] = val_q;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_WR; i++) begin
      if (rd_addr == slot_addr(i)) rd_data = bank_flat[i*DATA_W +: DATA_W];
    end
    if (rd_addr == STATUS_ADDR) rd_data = status_word;
  end

  logic cal_d, cal_q, cal_cur;
  assign cal_cur = bank_flat[FILT_SLOT*DATA_W + CAL_BIT];
  assign cal_d   = wr_en && (wr_addr == slot_addr(FILT_SLOT)) &&
                   wr_data[CAL_BIT] && !cal_cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cal_q <= 1'b0;
    else        cal_q <= cal_d;
  end
  assign cal_start = cal_q;
endmodule

// File: rtl/spi_read_tx.sv
module spi_read_tx
  import spi_regslave_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sen_fall,
  input  logic              sen_rise,
  input  logic              sclk_fall,
  input  logic              ptr_wr,
  input  logic [ADDR_W-1:0] ptr_val,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_ptr,
  output logic              armed,
  output logic              busy,
  output logic              sdo
);
  logic              armed_q, armed_d, busy_q, busy_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              upd_en;

  assign upd_en = ptr_wr | sen_fall | sen_rise | (busy_q & sclk_fall);

  always_comb begin
    armed_d = armed_q;
    busy_d  = busy_q;
    ptr_d   = ptr_q;
    sh_d    = sh_q;
    if (ptr_wr) begin
      armed_d = 1'b1;
      ptr_d   = ptr_val;
    end
    if (sen_fall) begin
      armed_d = 1'b0;
      if (armed_q) begin
        busy_d = 1'b1;
        sh_d   = rd_data;
      end
    end else if (busy_q && sclk_fall) begin
      sh_d = {sh_q[DATA_W-2:0], 1'b0};
    end
    if (sen_rise) busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      busy_q  <= 1'b0;
      ptr_q   <= '0;
      sh_q    <= '0;
    end else if (upd_en) begin
      armed_q <= armed_d;
      busy_q  <= busy_d;
      ptr_q   <= ptr_d;
      sh_q    <= sh_d;
    end
  end

  assign rd_ptr = ptr_q;
  assign armed  = armed_q;
  assign busy   = busy_q;
  assign sdo    = busy_q & sh_q[DATA_W-1];
endmodule

// File: rtl/spi_regslave.sv
module spi_regslave
  import spi_regslave_pkg::*;
#(
  parameter logic [CHIP_W-1:0] CHIP_ADDR = 3'b110
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        spi_sen_n,
  input  logic        spi_sclk,
  input  logic        spi_sdi,
  output logic        spi_sdo,
  output logic        spi_sdo_oe,
  input  logic        stat_cal_ovfl,
  input  logic        stat_cal_done,
  input  logic [7:0]  stat_cal_word,
  output logic [15:0] cfg_enable,
  output logic [15:0] cfg_filter,
  output logic [15:0] cfg_filter_src,
  output logic [15:0] cfg_agc,
  output logic [15:0] cfg_gain_limit,
  output logic [15:0] cfg_blocker,
  output logic [15:0] cfg_phase_i,
  output logic [15:0] cfg_phase_q,
  output logic        cal_start
);
  // reset: asserted asynchronously, released on clk
  logic [1:0] rst_sync_q;
  logic       rst_n_int;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  // bit 0 = enable, bit 1 = serial clock, bit 2 = data
  logic [2:0] lvl;
  logic [1:0] rise, fall;
  spi_sync_edge #(.W(3), .EDGE_W(2), .RST_VAL(3'b001)) sync_i (
    .clk(clk), .rst_n(rst_n_int),
    .d({spi_sdi, spi_sclk, spi_sen_n}),
    .level(lvl), .rise(rise), .fall(fall)
  );

  logic sen_rise, sen_fall, sclk_rise, sclk_fall;
  assign sen_rise  = rise[0];
  assign sen_fall  = fall[0];
  assign sclk_rise = rise[1];
  assign sclk_fall = fall[1];

  logic              frame_ok;
  logic [ADDR_W-1:0] frame_addr;
  logic [DATA_W-1:0] frame_data;
  spi_frame_rx #(.CHIP_ADDR(CHIP_ADDR)) rx_i (
    .clk(clk), .rst_n(rst_n_int),
    .sen_low(~lvl[0]), .sen_fall(sen_fall), .sen_rise(sen_rise),
    .sclk_rise(sclk_rise), .sdi(lvl[2]),
    .frame_ok(frame_ok), .frame_addr(frame_addr), .frame_data(frame_data)
  );

  logic              rd_busy, rd_armed, ptr_wr, bank_wr;
  logic [ADDR_W-1:0] rd_ptr;
  logic [DATA_W-1:0] rd_data, status_word;
  logic [NUM_WR*DATA_W-1:0] bank_flat;

  assign bank_wr     = frame_ok && !rd_busy;
  assign ptr_wr      = bank_wr && (frame_addr == PTR_ADDR) &&
                       (frame_data[DATA_W-1:ADDR_W] == '0);
  assign status_word = {{STAT_PAD_W{1'b0}}, stat_cal_ovfl, stat_cal_done, stat_cal_word};

  spi_reg_bank bank_i (
    .clk(clk), .rst_n(rst_n_int),
    .wr_en(bank_wr), .wr_addr(frame_addr), .wr_data(frame_data),
    .rd_addr(rd_ptr), .status_word(status_word),
    .bank_flat(bank_flat), .rd_data(rd_data), .cal_start(cal_start)
  );

  spi_read_tx tx_i (
    .clk(clk), .rst_n(rst_n_int),
    .sen_fall(sen_fall), .sen_rise(sen_rise), .sclk_fall(sclk_fall),
    .ptr_wr(ptr_wr), .ptr_val(frame_data[ADDR_W-1:0]), .rd_data(rd_data),
    .rd_ptr(rd_ptr), .armed(rd_armed), .busy(rd_busy), .sdo(spi_sdo)
  );
  assign spi_sdo_oe = rd_busy;

  assign cfg_enable     = bank_flat[0*DATA_W +: DATA_W];
  assign cfg_filter     = bank_flat[1*DATA_W +: DATA_W];
  assign cfg_filter_src = bank_flat[2*DATA_W +: DATA_W];
  assign cfg_agc        = bank_flat[3*DATA_W +: DATA_W];
  assign cfg_gain_limit = bank_flat[4*DATA_W +: DATA_W];
  assign cfg_blocker    = bank_flat[5*DATA_W +: DATA_W];
  assign cfg_phase_i    = bank_flat[6*DATA_W +: DATA_W];
  assign cfg_phase_q    = bank_flat[7*DATA_W +: DATA_W];
endmodule

// File: rtl/spi_regslave_chk.sv
module spi_regslave_chk
  import spi_regslave_pkg::*;
(
  input logic                     clk,
  input logic                     rst_n,
  input logic                     bank_wr,
  input logic [NUM_WR*DATA_W-1:0] bank_flat,
  input logic                     cal_start,
  input logic                     sdo_oe,
  input logic                     armed,
  input logic                     sen_rise
);
  // R3: outputs move only on the edge after a commit
  a_r3_change_needs_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bank_flat) |-> $past(bank_wr));

  // R8: a readback frame opens only from the armed state
  a_r8_oe_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> $past(armed));

  // R9: drive enable drops only when the frame closes
  a_r9_oe_ends_at_close: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sdo_oe) |-> $past(sen_rise));

  // R10: single-cycle pulse
  a_r10_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start |=> !cal_start);

  // R10: pulse only when the enable bit has just risen
  a_r10_pulse_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start |-> (bank_flat[FILT_SLOT*DATA_W + CAL_BIT] &&
                   !$past(bank_flat[FILT_SLOT*DATA_W + CAL_BIT])));
endmodule

bind spi_regslave spi_regslave_chk chk_i (
  .clk(clk), .rst_n(rst_n_int), .bank_wr(bank_wr), .bank_flat(bank_flat),
  .cal_start(cal_start), .sdo_oe(spi_sdo_oe), .armed(rd_armed), .sen_rise(sen_rise)
);

// File: tb/spi_regslave_tb_top.sv
module spi_regslave_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;
  localparam logic [2:0] CHIP = 3'b110;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        spi_sen_n, spi_sclk, spi_sdi;
  logic        spi_sdo, spi_sdo_oe;
  logic        stat_cal_ovfl, stat_cal_done;
  logic [7:0]  stat_cal_word;
  logic [15:0] cfg_enable, cfg_filter, cfg_filter_src, cfg_agc;
  logic [15:0] cfg_gain_limit, cfg_blocker, cfg_phase_i, cfg_phase_q;
  logic        cal_start;

  int n_chk  = 0;
  int n_fail = 0;
  int cal_cnt = 0;
  logic [15:0] exp_mem [0:31];

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_regslave dut_i (
    .clk(clk), .rst_n(rst_n),
    .spi_sen_n(spi_sen_n), .spi_sclk(spi_sclk), .spi_sdi(spi_sdi),
    .spi_sdo(spi_sdo), .spi_sdo_oe(spi_sdo_oe),
    .stat_cal_ovfl(stat_cal_ovfl), .stat_cal_done(stat_cal_done),
    .stat_cal_word(stat_cal_word),
    .cfg_enable(cfg_enable), .cfg_filter(cfg_filter), .cfg_filter_src(cfg_filter_src),
    .cfg_agc(cfg_agc), .cfg_gain_limit(cfg_gain_limit), .cfg_blocker(cfg_blocker),
    .cfg_phase_i(cfg_phase_i), .cfg_phase_q(cfg_phase_q), .cal_start(cal_start)
  );

  always @(posedge clk) if (rst_n && cal_start) cal_cnt++;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit writable(input logic [4:0] a);
    return a inside {5'h01, 5'h02, 5'h03, 5'h04, 5'h05, 5'h12, 5'h14, 5'h15};
  endfunction

  function automatic logic [15:0] status_exp();
    return {6'b0, stat_cal_ovfl, stat_cal_done, stat_cal_word};
  endfunction

  function automatic logic [63:0] mk(input logic [2:0] c, input logic [4:0] a,
                                     input logic [15:0] d);
    return {40'b0, c, a, d};
  endfunction

  task automatic check_outputs(input string req);
    chk({req, " 0x01"}, 32'(cfg_enable),     32'(exp_mem[5'h01]));
    chk({req, " 0x02"}, 32'(cfg_filter),     32'(exp_mem[5'h02]));
    chk({req, " 0x03"}, 32'(cfg_filter_src), 32'(exp_mem[5'h03]));
    chk({req, " 0x04"}, 32'(cfg_agc),        32'(exp_mem[5'h04]));
    chk({req, " 0x05"}, 32'(cfg_gain_limit), 32'(exp_mem[5'h05]));
    chk({req, " 0x12"}, 32'(cfg_blocker),    32'(exp_mem[5'h12]));
    chk({req, " 0x14"}, 32'(cfg_phase_i),    32'(exp_mem[5'h14]));
    chk({req, " 0x15"}, 32'(cfg_phase_q),    32'(exp_mem[5'h15]));
  endtask

  task automatic close_frame();
    spi_sen_n = 1'b1;
    tick(2*HALF);
  endtask

  task automatic run_frame(input int nbits, input logic [63:0] bits, input bit keep_open,
                           output logic [15:0] rd, output bit oe_seen);
    rd = '0;
    oe_seen = 1'b0;
    spi_sen_n = 1'b0;
    tick(HALF);
    for (int i = 0; i < nbits; i++) begin
      spi_sclk = 1'b0;
      spi_sdi  = bits[nbits-1-i];
      tick(HALF);
      if (spi_sdo_oe) oe_seen = 1'b1;
      if (i < 16) rd[15-i] = spi_sdo;
      spi_sclk = 1'b1;
      tick(HALF);
    end
    spi_sclk = 1'b0;
    tick(HALF);
    if (!keep_open) close_frame();
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    logic [15:0] rd;
    bit oe;
    run_frame(24, mk(CHIP, a, d), 1'b0, rd, oe);
  endtask

  task automatic rd_reg(input logic [4:0] a, input logic [63:0] rd_frame,
                        output logic [15:0] data, output bit oe);
    logic [15:0] dummy;
    bit oe0;
    run_frame(24, mk(CHIP, 5'h07, {11'b0, a}), 1'b0, dummy, oe0);
    run_frame(24, rd_frame, 1'b0, data, oe);
  endtask

  initial begin
    logic [15:0] rdv, d;
    bit oe;
    int base;

    for (int a = 0; a < 32; a++) exp_mem[a] = 16'h0000;
    exp_mem[5'h01] = 16'hFFB6; exp_mem[5'h02] = 16'hC585;
    exp_mem[5'h03] = 16'h869F; exp_mem[5'h04] = 16'h3400;
    exp_mem[5'h05] = 16'hA904; exp_mem[5'h12] = 16'hF05C;
    exp_mem[5'h14] = 16'hF000; exp_mem[5'h15] = 16'hF000;

    rst_n = 1'b0; spi_sen_n = 1'b1; spi_sclk = 1'b0; spi_sdi = 1'b0;
    stat_cal_ovfl = 1'b1; stat_cal_done = 1'b1; stat_cal_word = 8'h85;
    tick(5);
    rst_n = 1'b1;
    tick(6);

    // R5 reset values, R9 idle
    check_outputs("R5 reset");
    chk("R9 idle oe", 32'(spi_sdo_oe), 32'd0);
    chk("R10 idle pulse", 32'(cal_start), 32'd0);

    // R1 R6 write sweep over every address except the pointer
    for (int a = 0; a < 32; a++) begin
      if (a == 7) continue;
      d = {a[4:0], ~a[4:0], a[4:0], 1'b1};
      wr(a[4:0], d);
      if (writable(a[4:0])) exp_mem[a] = d;
      check_outputs("R1 R6 sweep");
    end

    // R8 readback sweep, R6 status, unimplemented reads zero
    for (int a = 0; a < 32; a++) begin
      if (a == 7) continue;
      rd_reg(a[4:0], 64'h0, rdv, oe);
      chk("R8 readback data", 32'(rdv), 32'((a == 6) ? status_exp() : exp_mem[a]));
      chk("R9 readback oe", 32'(oe), 32'd1);
    end
    stat_cal_ovfl = 1'b0; stat_cal_word = 8'h3C;
    rd_reg(5'h06, 64'h0, rdv, oe);
    chk("R6 live status", 32'(rdv), 32'h013C);
    chk("R9 oe after close", 32'(spi_sdo_oe), 32'd0);

    // R3 no update while shifting, update on third edge after close
    run_frame(24, mk(CHIP, 5'h14, 16'h5A5A), 1'b1, rdv, oe);
    chk("R3 open frame", 32'(cfg_phase_i), 32'(exp_mem[5'h14]));
    spi_sen_n = 1'b1;
    tick(2);
    chk("R3 two edges", 32'(cfg_phase_i), 32'(exp_mem[5'h14]));
    tick(1);
    exp_mem[5'h14] = 16'h5A5A;
    chk("R3 third edge", 32'(cfg_phase_i), 32'h5A5A);
    tick(2*HALF);

    // R2 every other chip code is discarded
    for (int c = 0; c < 8; c++) begin
      if (c == int'(CHIP)) continue;
      run_frame(24, mk(c[2:0], 5'h04, 16'hFFFF), 1'b0, rdv, oe);
      check_outputs("R2 chip mismatch");
      run_frame(24, mk(c[2:0], 5'h07, 16'h0001), 1'b0, rdv, oe);
      run_frame(24, mk(CHIP, 5'h00, 16'h0000), 1'b0, rdv, oe);
      chk("R2 R9 no arm", 32'(oe), 32'd0);
    end

    // R4 wrong lengths
    run_frame(23, mk(CHIP, 5'h04, 16'h1111) >> 1, 1'b0, rdv, oe);
    check_outputs("R4 23 clocks");
    run_frame(25, mk(CHIP, 5'h04, 16'h2222) << 1, 1'b0, rdv, oe);
    check_outputs("R4 25 clocks");
    run_frame(56, {32'hFFFF_FFFF, mk(CHIP, 5'h04, 16'h3333)} , 1'b0, rdv, oe);
    check_outputs("R4 56 clocks");

    // R7 pointer with upper bits set arms nothing
    run_frame(24, mk(CHIP, 5'h07, 16'h0802), 1'b0, rdv, oe);
    run_frame(24, mk(CHIP, 5'h00, 16'h0000), 1'b0, rdv, oe);
    chk("R7 bad pointer oe", 32'(oe), 32'd0);

    // R8 content of a readback frame is never committed
    rd_reg(5'h15, mk(CHIP, 5'h14, 16'h1234), rdv, oe);
    chk("R8 read 0x15", 32'(rdv), 32'(exp_mem[5'h15]));
    check_outputs("R8 read frame not committed");

    // R10 calibration pulse on 0 to 1 only
    wr(5'h02, 16'hC585); exp_mem[5'h02] = 16'hC585;
    base = cal_cnt;
    wr(5'h02, 16'hC785); exp_mem[5'h02] = 16'hC785;
    chk("R10 rising bit", 32'(cal_cnt - base), 32'd1);
    wr(5'h02, 16'hC785);
    chk("R10 already set", 32'(cal_cnt - base), 32'd1);
    wr(5'h02, 16'hC585);
    wr(5'h02, 16'hC785);
    chk("R10 second rise", 32'(cal_cnt - base), 32'd2);
    check_outputs("R10 final");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule